// File: doc/BRIEF.md
# Timer Match Output Controller

This block is a 16-bit timer/counter with four compare channels. Each channel holds a match value and owns one output bit. When the running count reaches a channel's match value, that channel's output is left alone, forced low, forced high or inverted. The choice comes from a 2-bit action code that belongs to that channel. Channels 0 to 2 also drive an output pin. Channel 3 has no pin, but its bit can be read like the others.

Software reaches everything through a small word-addressed register port. The write is synchronous and the read is combinational. The count source is set in a mode register. In timer mode the count advances on a programmable prescaled clock. In counter mode it advances on edges of one selected external input, which is first passed through a two-flop synchronizer. A control register gates counting and can hold the count at zero.

Top module: `tmr_match_ctl`

## Requirements
- R1: After reset, the output bits, action codes, control, mode, prescale, match values and count are all 0, and every match pin is low.
- R2: Register map, word addresses: 0 control (bit 0 enable, bit 1 clear), 1 prescale limit, 2 count (read-only), 3 mode, 4 to 7 match values of channels 0 to 3, 8 match-output register. In the match-output register, bit i holds output bit i (i = 0..3) and bits 5:4, 7:6, 9:8 and 11:10 hold the action codes of channels 0 to 3. Writes to bits 31:12 are ignored and those bits read as 0.
- R3: Action codes are 00 keep, 01 force 0, 10 force 1 and 11 invert. The output bit takes its new value one clock after the cycle in which the count first equals the channel's match value.
- R4: A match is taken once per arrival of equality. While the count stays equal to the match value, an invert code flips the bit only once. Changing the match value away and back arms a new match.
- R5: Software may write the output bits directly. When a match action lands in the same clock as a software write to the match-output register, the match action decides that channel's bit.
- R6: In timer mode (mode bits 1:0 = 00) with prescale limit P and enable set, the count advances once every P+1 clocks. With enable clear, the count does not change.
- R7: While the clear bit is set, the count and the prescaler stay at 0, even if enable is set.
- R8: The count wraps from 0xFFFF to 0, and a match value of 0xFFFF triggers its action.
- R9: In counter mode, mode bits 1:0 choose the counted edge: 01 rising, 10 falling, 11 both. Mode bits 3:2 pick the input index. Edges on inputs that are not selected have no effect.
- R10: Match pins 0 to 2 always equal output bits 0 to 2. Output bit 3 drives no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| cnt_in | input | 4 | External count inputs, asynchronous |
| mat_pin | output | 3 | Match outputs of channels 0 to 2 |

## Verification
Each output bit is a single flop that is changed only by a match or by a software write. A wrong bit therefore stays wrong, and it is visible on the pin and in the match-output register from the clock after the faulty event until something writes that bit again. A wrong count or prescaler phase does not show at once. It shows as a count read-back that is off after a timed window, and as a match action that fires one or more ticks early or late. The sweeps compare both against arithmetic expectations. A broken edge qualifier in the compare shows as a repeated inversion while the count is held.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      SRC_TIMER = 2'b00,
      SRC_RISE  = 2'b01,
      SRC_FALL  = 2'b10,
      SRC_BOTH  = 2'b11
   } src_e;

   localparam int ADR_CTRL   = 0;
   localparam int ADR_PRESC  = 1;
   localparam int ADR_COUNT  = 2;
   localparam int ADR_MODE   = 3;
   localparam int ADR_MATCH0 = 4;
   localparam int ADR_OUTS   = 8;

   localparam int OUTS_USED  = 12;
   localparam int ACT_LSB    = 4;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int PS_W = 16,
   parameter int NIN  = 4,
   localparam int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  src_e             src,
   input  logic [SEL_W-1:0] in_sel,
   input  logic [NIN-1:0]   cnt_in,
   input  logic [PS_W-1:0]  ps_lim,
   output logic             tick
);

   if (NIN < 1 || NIN > 4) begin : g_bad_nin
      $error("tmr_tick_gen: NIN must be 1..4");
   end

   logic       pick;
   logic [2:0] sync_q;
   logic [PS_W-1:0] ps_q;
   logic       rise, fall, fire;

   if (NIN == 1) begin : g_one_in
      logic unused_sel;
      assign unused_sel = ^in_sel;
      assign pick = cnt_in[0];
   end else begin : g_mux_in
      always_comb begin
         pick = 1'b0;
         for (int k = 0; k < NIN; k++) begin
            if (in_sel == SEL_W'(k)) pick = cnt_in[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[1:0], pick};
   end

   assign rise = sync_q[1] & ~sync_q[2];
   assign fall = ~sync_q[1] & sync_q[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ps_q <= '0;
      else if (clr)                        ps_q <= '0;
      else if (run && src == SRC_TIMER)    ps_q <= (ps_q == ps_lim) ? '0 : ps_q + 1'b1;
   end

   always_comb begin
      unique case (src)
         SRC_TIMER: fire = (ps_q == ps_lim);
         SRC_RISE:  fire = rise;
         SRC_FALL:  fire = fall;
         default:   fire = rise | fall;
      endcase
   end

   assign tick = run & ~clr & fire;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] mval,
   input  act_e             act,
   input  logic             sw_we,
   input  logic             sw_bit,
   output logic             em,
   output logic             hit
);

   logic eq, eq_q;

   assign eq  = (cnt == mval);
   assign hit = eq & ~eq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_q <= 1'b0;
      else        eq_q <= eq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         em <= 1'b0;
      end else if (hit) begin
         unique case (act)
            ACT_KEEP: em <= em;
            ACT_LOW:  em <= 1'b0;
            ACT_HIGH: em <= 1'b1;
            default:  em <= ~em;
         endcase
      end else if (sw_we) begin
         em <= sw_bit;
      end
   end

endmodule

// File: rtl/tmr_match_ctl.sv
module tmr_match_ctl
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NCH    = 4,
   parameter int NIN    = 4,
   parameter int PS_W   = 16,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   localparam int PIN_N = (NCH > 3) ? 3 : NCH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NIN-1:0]    cnt_in,
   output logic [PIN_N-1:0]  mat_pin
);

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("tmr_match_ctl: NCH must be 1..4");
   end
   if (DATA_W <= OUTS_USED || CNT_W > DATA_W || PS_W > DATA_W) begin : g_bad_w
      $error("tmr_match_ctl: DATA_W too narrow");
   end
   if ((1 << ADDR_W) <= ADR_OUTS) begin : g_bad_a
      $error("tmr_match_ctl: ADDR_W too narrow");
   end

   logic [1:0]        ctrl_q;
   logic [PS_W-1:0]   ps_lim_q;
   logic [3:0]        mode_q;
   logic [CNT_W-1:0]  mr_q  [NCH];
   act_e              act_q [NCH];
   logic [CNT_W-1:0]  cnt_q;
   logic [NCH-1:0]    em_v;
   logic [NCH-1:0]    hit_v;
   logic              tick;
   logic              emr_we;

   assign emr_we = reg_we && (reg_addr == ADDR_W'(ADR_OUTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         ps_lim_q <= '0;
         mode_q   <= '0;
         for (int i = 0; i < NCH; i++) begin
            mr_q[i]  <= '0;
            act_q[i] <= ACT_KEEP;
         end
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(ADR_CTRL))  ctrl_q   <= reg_wdata[1:0];
         if (reg_addr == ADDR_W'(ADR_PRESC)) ps_lim_q <= reg_wdata[PS_W-1:0];
         if (reg_addr == ADDR_W'(ADR_MODE))  mode_q   <= reg_wdata[3:0];
         for (int i = 0; i < NCH; i++) begin
            if (reg_addr == ADDR_W'(ADR_MATCH0 + i)) mr_q[i] <= reg_wdata[CNT_W-1:0];
            if (reg_addr == ADDR_W'(ADR_OUTS))
               act_q[i] <= act_e'(reg_wdata[ACT_LSB + 2*i +: 2]);
         end
      end
   end

   tmr_tick_gen #(.PS_W(PS_W), .NIN(NIN)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl_q[0]),
      .clr    (ctrl_q[1]),
      .src    (src_e'(mode_q[1:0])),
      .in_sel (mode_q[3:2]),
      .cnt_in (cnt_in),
      .ps_lim (ps_lim_q),
      .tick   (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctrl_q[1]),
      .tick  (tick),
      .cnt   (cnt_q)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .cnt    (cnt_q),
         .mval   (mr_q[i]),
         .act    (act_q[i]),
         .sw_we  (emr_we),
         .sw_bit (reg_wdata[i]),
         .em     (em_v[i]),
         .hit    (hit_v[i])
      );
   end

   for (genvar i = 0; i < PIN_N; i++) begin : g_pin
      assign mat_pin[i] = em_v[i];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_CTRL))  reg_rdata[1:0]      = ctrl_q;
      if (reg_addr == ADDR_W'(ADR_PRESC)) reg_rdata[PS_W-1:0] = ps_lim_q;
      if (reg_addr == ADDR_W'(ADR_COUNT)) reg_rdata[CNT_W-1:0] = cnt_q;
      if (reg_addr == ADDR_W'(ADR_MODE))  reg_rdata[3:0]      = mode_q;
      for (int i = 0; i < NCH; i++) begin
         if (reg_addr == ADDR_W'(ADR_MATCH0 + i)) reg_rdata[CNT_W-1:0] = mr_q[i];
         if (reg_addr == ADDR_W'(ADR_OUTS)) begin
            reg_rdata[i]                 = em_v[i];
            reg_rdata[ACT_LSB + 2*i +: 2] = act_q[i];
         end
      end
   end

endmodule

// File: rtl/tmr_match_chk.sv
module tmr_match_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NCH    = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic [1:0]        ctrl,
   input logic [NCH-1:0]    hit,
   input logic [NCH-1:0]    em,
   input act_e              act [NCH],
   input logic              emr_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata
);

   AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl[1]) |-> (cnt == '0)); // R7

   AST_IDLE_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl[0]) && !$past(ctrl[1])) |-> $stable(cnt)); // R6

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt)) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1))); // R8

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(ADR_OUTS)) |-> (reg_rdata[DATA_W-1:OUTS_USED] == '0)); // R2

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         hit[i] |=> !hit[i]); // R4

      AST_FLIP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && act[i] == ACT_FLIP) |=> (em[i] != $past(em[i]))); // R3

      AST_HIT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && emr_we && act[i] == ACT_HIGH) |=> em[i]); // R5

      AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(hit[i]) && !$past(emr_we)) |-> $stable(em[i])); // R3
   end

endmodule

bind tmr_match_ctl tmr_match_chk #(
   .CNT_W  (CNT_W),
   .NCH    (NCH),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt_q),
   .ctrl      (ctrl_q),
   .hit       (hit_v),
   .em        (em_v),
   .act       (act_q),
   .emr_we    (emr_we),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata)
);

// File: tb/tmr_match_ctl_test.sv
`timescale 1ns/1ps
module tmr_match_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  cnt_in = '0;
   logic [2:0]  mat_pin;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   tmr_match_ctl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cnt_in    (cnt_in),
      .mat_pin   (mat_pin)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); cnt_in[idx] = 1'b1;
      repeat (4) @(negedge clk);
      cnt_in[idx] = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic apply(input logic b, input int code);
      case (code)
         0: return b;
         1: return 1'b0;
         2: return 1'b1;
         default: return ~b;
      endcase
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      logic [31:0] d, d2, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a <= 8; a++) begin
         rd(a, d);
         check($sformatf("R1 reg %0d after reset", a), d, 32'h0);
      end
      check("R1 pins after reset", {29'h0, mat_pin}, 32'h0);

      // R3: all action codes on every channel from every starting state
      for (int a = 4; a <= 7; a++) wr(a, 32'd3);
      for (int init = 0; init < 16; init++) begin
         for (int p = 0; p < 4; p++) begin
            logic [31:0] w;
            w = 32'(init);
            exp = '0;
            for (int i = 0; i < 4; i++) begin
               int code;
               code = (p + i) % 4;
               w[4 + 2*i +: 2] = 2'(code);
               exp[4 + 2*i +: 2] = 2'(code);
               exp[i] = apply(init[i], code);
            end
            wr(0, 32'h2);
            wr(8, w);
            wr(0, 32'h1);
            repeat (10) @(negedge clk);
            wr(0, 32'h0);
            rd(8, d);
            check($sformatf("R3 init=%0h pat=%0d", init, p), d, exp);
            check($sformatf("R10 pins init=%0h pat=%0d", init, p), {29'h0, mat_pin}, {29'h0, exp[2:0]});
         end
      end

      // R5: match in the same clock as a software write to the same bit
      wr(0, 32'h2);
      wr(0, 32'h0);
      wr(8, 32'h30);
      @(negedge clk); reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0;
      @(negedge clk); reg_addr = 4'd8; reg_wdata = 32'h30;
      @(negedge clk); reg_we = 1'b0;
      rd(8, d);
      check("R5 match beats write", d & 32'h1, 32'h1);

      // R4: held count inverts only once; re-arming inverts again
      repeat (10) @(negedge clk);
      rd(8, d);
      check("R4 single invert while held", d & 32'h1, 32'h1);
      wr(4, 32'd5);
      wr(4, 32'd0);
      repeat (3) @(negedge clk);
      rd(8, d);
      check("R4 re-armed invert", d & 32'h1, 32'h0);

      // R6: timer mode with prescale 0 and 3
      wr(1, 32'd0);
      wr(0, 32'h2);
      wr(0, 32'h1);
      repeat (38) @(negedge clk);
      wr(0, 32'h0);
      rd(2, d);
      check("R6 prescale 0 count", d, 32'd40);
      repeat (5) @(negedge clk);
      rd(2, d2);
      check("R6 disabled holds", d2, 32'd40);
      wr(1, 32'd3);
      wr(0, 32'h2);
      wr(0, 32'h1);
      repeat (38) @(negedge clk);
      wr(0, 32'h0);
      rd(2, d);
      check("R6 prescale 3 count", d, 32'd10);

      // R7: clear wins over enable
      wr(0, 32'h3);
      repeat (12) @(negedge clk);
      rd(2, d);
      check("R7 clear holds zero", d, 32'd0);

      // R8: wrap and a match at the top value (channel 3 code 10 = force 1)
      wr(1, 32'd0);
      wr(0, 32'h2);
      wr(8, 32'h800);
      wr(7, 32'hFFFF);
      wr(0, 32'h1);
      repeat (65537) @(negedge clk);
      wr(0, 32'h0);
      rd(2, d);
      check("R8 wrapped count", d, 32'd3);
      rd(8, d);
      check("R8 match at top value", d, 32'h808);
      check("R10 bit 3 has no pin", {29'h0, mat_pin}, 32'h0);

      // R2: reserved bits ignored and read as 0
      wr(8, 32'hFFFF_F5A5);
      rd(8, d);
      check("R2 reserved bits", d, 32'h0000_05A5);
      check("R10 pins mirror bits", {29'h0, mat_pin}, 32'h5);
      wr(0, 32'hFFFF_FFFC);
      rd(0, d);
      check("R2 control upper bits", d, 32'h0);

      // R9: counter mode on input 1
      wr(0, 32'h2);
      wr(3, 32'h5);
      wr(0, 32'h1);
      for (int k = 0; k < 5; k++) pulse(1);
      pulse(0); pulse(0); pulse(2);
      repeat (4) @(negedge clk);
      rd(2, d);
      check("R9 rising edges, others ignored", d, 32'd5);
      wr(0, 32'h2);
      wr(3, 32'h6);
      wr(0, 32'h1);
      for (int k = 0; k < 5; k++) pulse(1);
      repeat (4) @(negedge clk);
      rd(2, d);
      check("R9 falling edges", d, 32'd5);
      wr(0, 32'h2);
      wr(3, 32'h7);
      wr(0, 32'h1);
      for (int k = 0; k < 5; k++) pulse(1);
      repeat (4) @(negedge clk);
      rd(2, d);
      check("R9 both edges", d, 32'd10);
      wr(0, 32'h2);
      wr(3, 32'hD);
      wr(0, 32'h1);
      for (int k = 0; k < 3; k++) pulse(1);
      for (int k = 0; k < 2; k++) pulse(3);
      repeat (4) @(negedge clk);
      rd(2, d);
      check("R9 input select 3", d, 32'd2);
      wr(0, 32'h0);

      summary();
   end

endmodule